// File: doc/BRIEF.md
# Wait-for-Exception Stall Controller

This block sits next to a processor's execute stage and gives it a "wait until something happens" instruction. When a wait instruction whose condition field is zero finishes in the execute stage, the controller raises a wait-state bit. That bit is ORed into the stage's stall output, so no new instruction is accepted and the stage register keeps its contents. The wait state ends when any wake source appears: a pending trace exception, an external interrupt request, a performance-monitor interrupt request, a negative decrementer, or a delivered interrupt. None of these is gated by an interrupt-enable bit. A wait instruction with a nonzero condition field completes as a no-op.

The block contains its own decrementer. Software loads it through a write strobe and it counts down by one on each timebase tick, so it can be tested without the rest of the core. The decrementer's top bit acts as the "negative" wake source.

Top module: `wait_stall_top`

## Requirements
- R1: A wait instruction (isWaitOp high) that is accepted with insnIn bits 22:21 equal to 00 leaves waitState low in the cycle after acceptance, while it completes in the stage register. waitState goes high at the clock edge that ends that completion cycle.
- R2: A wait instruction whose bits 22:21 are 01, 10 or 11 completes without setting waitState and without raising busyOut.
- R3: Any one of tracePending, extIrq, pmuIrq, intrDeliver, or decrementer bit DEC_W-1 being set clears waitState at the next clock edge. No enable input gates these sources.
- R4: busyOut is high whenever any bit of unitBusy is high or waitState is high, and low otherwise.
- R5: acceptOut is high only when inValid is high and busyOut, flushIn, redirectIn and intrActive are all low.
- R6: While busyOut is high, heldInsn keeps its value. Otherwise heldInsn captures insnIn on each accepted instruction.
- R7: Under reset, waitState, busyOut (with unitBusy low), heldInsn and decValue are all zero.
- R8: When a wake source is present in the same cycle that a qualifying wait completes, waitState stays low.
- R9: decLoad loads decLoadVal, taking priority over decTick. Each decTick without a load lowers decValue by one, and decValue wraps from zero to all ones, which sets the top bit and wakes a waiting core.
- R10: In the cycle after waitState clears, busyOut is low again unless a unit is busy, so a new instruction can be accepted.
- R11: An instruction that is not a wait (isWaitOp low) never sets waitState, even when its bits 22:21 are 00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| inValid | input | 1 | An instruction is offered to the stage |
| isWaitOp | input | 1 | The offered instruction decodes as the wait opcode |
| insnIn | input | INSN_W | Offered instruction word; bits 22:21 hold the wait condition |
| unitBusy | input | NUM_BUSY | Busy flags from the other execution units |
| flushIn | input | 1 | Pipeline flush in progress |
| redirectIn | input | 1 | Fetch redirect in progress |
| intrActive | input | 1 | Interrupt entry in progress |
| tracePending | input | 1 | Trace exception pending |
| extIrq | input | 1 | External interrupt request |
| pmuIrq | input | 1 | Performance-monitor interrupt request |
| intrDeliver | input | 1 | Interrupt being delivered this cycle |
| decLoad | input | 1 | Write strobe for the decrementer |
| decLoadVal | input | DEC_W | Value written into the decrementer |
| decTick | input | 1 | Timebase tick that decrements the decrementer |
| busyOut | output | 1 | Combined stall toward the preceding stage |
| acceptOut | output | 1 | The offered instruction is accepted this cycle |
| waitState | output | 1 | The core is waiting for an exception |
| heldInsn | output | INSN_W | Instruction word held in the stage register |
| decValue | output | DEC_W | Current decrementer value |

## Verification
The bench builds the block with DEC_W of 16 and NUM_BUSY of 3. The narrow decrementer means a small loaded value can tick through zero and set the top bit within a few cycles. It also lets the random phase reach negative values naturally, alongside the loads that deliberately set the sign bit. The three busy lines show that the stall merges every unit's flag with the wait state. The directed cases cover:
- each wake source separately;
- every nonzero condition code;
- a non-wait instruction with a zero condition field;
- the wake-versus-entry collision.

// File: rtl/wait_stall_pkg.sv
package wait_stall_pkg;
  // Strobes from the control to the stage datapath
  typedef struct packed {
    logic stageLoad;   // stage register may update this cycle
    logic take;        // an instruction is accepted this cycle
    logic takeEnters;  // the accepted instruction will enter the wait state
  } stageStrobes_t;
endpackage

// File: rtl/wait_stall_dp.sv
module wait_stall_dp
  import wait_stall_pkg::*;
#(
  parameter int INSN_W = 32,
  parameter int DEC_W  = 64
) (
  input  logic                clk,
  input  logic                rstN,
  input  stageStrobes_t       strobes,
  input  logic [INSN_W-1:0]   insnIn,
  input  logic                decLoad,
  input  logic [DEC_W-1:0]    decLoadVal,
  input  logic                decTick,
  output logic                completeEnter,
  output logic                decNegative,
  output logic [DEC_W-1:0]    decValue,
  output logic [INSN_W-1:0]   heldInsn
);
  localparam int DecMsb = DEC_W - 1;

  logic stageValid;
  logic stageEnters;

  // Stage register: payload held while stalled, completion flag consumed once
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      stageValid  <= 1'b0;
      stageEnters <= 1'b0;
      heldInsn    <= '0;
    end else if (strobes.stageLoad) begin
      stageValid  <= strobes.take;
      stageEnters <= strobes.takeEnters;
      if (strobes.take) heldInsn <= insnIn;
    end else begin
      stageValid  <= 1'b0;
    end
  end

  assign completeEnter = stageValid && stageEnters;

  // Decrementer: load has priority, wraps through zero
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)        decValue <= '0;
    else if (decLoad) decValue <= decLoadVal;
    else if (decTick) decValue <= decValue - 1'b1;
  end

  assign decNegative = decValue[DecMsb];

  // R6
  hold_while_busy_chk: assert property (@(posedge clk) disable iff (!rstN)
    !strobes.stageLoad |=> $stable(heldInsn));

  // R5
  stage_from_accept_chk: assert property (@(posedge clk) disable iff (!rstN)
    stageValid |-> $past(strobes.take));

  // R9
  dec_step_chk: assert property (@(posedge clk) disable iff (!rstN)
    (decTick && !decLoad) |=> decValue == $past(decValue) - 1'b1);

  // R9
  dec_load_chk: assert property (@(posedge clk) disable iff (!rstN)
    decLoad |=> decValue == $past(decLoadVal));
endmodule

// File: rtl/wait_stall_ctrl.sv
module wait_stall_ctrl
  import wait_stall_pkg::*;
#(
  parameter int NUM_BUSY = 2
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                inValid,
  input  logic                isWaitOp,
  input  logic [1:0]          waitCond,
  input  logic [NUM_BUSY-1:0] unitBusy,
  input  logic                flushIn,
  input  logic                redirectIn,
  input  logic                intrActive,
  input  logic                tracePending,
  input  logic                extIrq,
  input  logic                pmuIrq,
  input  logic                intrDeliver,
  input  logic                decNegative,
  input  logic                completeEnter,
  output stageStrobes_t       strobes,
  output logic                busyOut,
  output logic                acceptOut,
  output logic                waitState
);
  logic wakeAny;
  logic waitNext;

  assign busyOut   = (|unitBusy) || waitState;
  assign acceptOut = inValid && !busyOut && !flushIn && !redirectIn && !intrActive;

  assign strobes.stageLoad  = !busyOut;
  assign strobes.take       = acceptOut;
  assign strobes.takeEnters = acceptOut && isWaitOp && (waitCond == 2'b00);

  // Wake sources are not qualified by any interrupt enable
  assign wakeAny = tracePending || extIrq || pmuIrq || decNegative || intrDeliver;

  always_comb begin
    waitNext = waitState;
    if (completeEnter) waitNext = 1'b1;
    if (wakeAny)       waitNext = 1'b0;   // clear wins over entry
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) waitState <= 1'b0;
    else       waitState <= waitNext;
  end

  // R1
  enter_on_complete_chk: assert property (@(posedge clk) disable iff (!rstN)
    (completeEnter && !wakeAny) |=> waitState);

  // R3
  wake_clears_chk: assert property (@(posedge clk) disable iff (!rstN)
    wakeAny |=> !waitState);

  // R1
  rise_needs_complete_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(waitState) |-> $past(completeEnter));

  // R4
  no_accept_waiting_chk: assert property (@(posedge clk) disable iff (!rstN)
    waitState |-> !acceptOut);
endmodule

// File: rtl/wait_stall_top.sv
module wait_stall_top
  import wait_stall_pkg::*;
#(
  parameter int NUM_BUSY = 2,
  parameter int INSN_W   = 32,
  parameter int DEC_W    = 64
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                inValid,
  input  logic                isWaitOp,
  input  logic [INSN_W-1:0]   insnIn,
  input  logic [NUM_BUSY-1:0] unitBusy,
  input  logic                flushIn,
  input  logic                redirectIn,
  input  logic                intrActive,
  input  logic                tracePending,
  input  logic                extIrq,
  input  logic                pmuIrq,
  input  logic                intrDeliver,
  input  logic                decLoad,
  input  logic [DEC_W-1:0]    decLoadVal,
  input  logic                decTick,
  output logic                busyOut,
  output logic                acceptOut,
  output logic                waitState,
  output logic [INSN_W-1:0]   heldInsn,
  output logic [DEC_W-1:0]    decValue
);
  localparam int WcLo = 21;
  localparam int WcHi = WcLo + 1;

  stageStrobes_t strobes;
  logic          completeEnter;
  logic          decNegative;

  wait_stall_ctrl #(.NUM_BUSY(NUM_BUSY)) uCtrl (
    .clk          (clk),
    .rstN         (rstN),
    .inValid      (inValid),
    .isWaitOp     (isWaitOp),
    .waitCond     (insnIn[WcHi:WcLo]),
    .unitBusy     (unitBusy),
    .flushIn      (flushIn),
    .redirectIn   (redirectIn),
    .intrActive   (intrActive),
    .tracePending (tracePending),
    .extIrq       (extIrq),
    .pmuIrq       (pmuIrq),
    .intrDeliver  (intrDeliver),
    .decNegative  (decNegative),
    .completeEnter(completeEnter),
    .strobes      (strobes),
    .busyOut      (busyOut),
    .acceptOut    (acceptOut),
    .waitState    (waitState)
  );

  wait_stall_dp #(.INSN_W(INSN_W), .DEC_W(DEC_W)) uDp (
    .clk          (clk),
    .rstN         (rstN),
    .strobes      (strobes),
    .insnIn       (insnIn),
    .decLoad      (decLoad),
    .decLoadVal   (decLoadVal),
    .decTick      (decTick),
    .completeEnter(completeEnter),
    .decNegative  (decNegative),
    .decValue     (decValue),
    .heldInsn     (heldInsn)
  );
endmodule

// File: tb/tb_wait_stall_top.sv
module tb_wait_stall_top;
  localparam int ClkPeriod = 10;
  localparam int NB = 3;
  localparam int IW = 32;
  localparam int DW = 16;

  logic clk = 0;
  logic rstN = 0;
  logic inValid, isWaitOp, flushIn, redirectIn, intrActive;
  logic tracePending, extIrq, pmuIrq, intrDeliver, decLoad, decTick;
  logic [IW-1:0] insnIn;
  logic [NB-1:0] unitBusy;
  logic [DW-1:0] decLoadVal;
  logic busyOut, acceptOut, waitState;
  logic [IW-1:0] heldInsn;
  logic [DW-1:0] decValue;

  int checks = 0;
  int fails = 0;
  bit done = 0;

  // reference state
  logic mWait, mStValid, mStEnter;
  logic [IW-1:0] mInsn;
  logic [DW-1:0] mDec;

  wait_stall_top #(.NUM_BUSY(NB), .INSN_W(IW), .DEC_W(DW)) dut (
    .clk(clk), .rstN(rstN), .inValid(inValid), .isWaitOp(isWaitOp), .insnIn(insnIn),
    .unitBusy(unitBusy), .flushIn(flushIn), .redirectIn(redirectIn), .intrActive(intrActive),
    .tracePending(tracePending), .extIrq(extIrq), .pmuIrq(pmuIrq), .intrDeliver(intrDeliver),
    .decLoad(decLoad), .decLoadVal(decLoadVal), .decTick(decTick), .busyOut(busyOut),
    .acceptOut(acceptOut), .waitState(waitState), .heldInsn(heldInsn), .decValue(decValue));

  always #(ClkPeriod/2) clk = ~clk;

  function automatic logic expBusy();
    return (|unitBusy) || mWait;
  endfunction

  function automatic logic expAccept();
    return inValid && !expBusy() && !flushIn && !redirectIn && !intrActive;
  endfunction

  function automatic logic expWake();
    return tracePending || extIrq || pmuIrq || intrDeliver || mDec[DW-1];
  endfunction

  task automatic chk(string tag, string what, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  task automatic clr();
    inValid = 0; isWaitOp = 0; insnIn = '0; unitBusy = '0; flushIn = 0; redirectIn = 0;
    intrActive = 0; tracePending = 0; extIrq = 0; pmuIrq = 0; intrDeliver = 0;
    decLoad = 0; decLoadVal = '0; decTick = 0;
  endtask

  // one cycle: check outputs against the reference, advance reference, cross the edge
  task automatic step(string tag);
    logic acc, nWait;
    #1;
    acc = expAccept();
    chk(tag, "busyOut", busyOut, expBusy());
    chk(tag, "acceptOut", acceptOut, acc);
    chk(tag, "waitState", waitState, mWait);
    chk(tag, "heldInsn", heldInsn, mInsn);
    chk(tag, "decValue", decValue, mDec);
    nWait = expWake() ? 1'b0 : ((mStValid && mStEnter) ? 1'b1 : mWait);
    if (!expBusy()) begin
      mStEnter = acc && isWaitOp && (insnIn[22:21] == 2'b00);
      mStValid = acc;
      if (acc) mInsn = insnIn;
    end else begin
      mStValid = 0;
    end
    if (decLoad) mDec = decLoadVal;
    else if (decTick) mDec = mDec - 1'b1;
    mWait = nWait;
    @(posedge clk);
    @(negedge clk);
  endtask

  function automatic logic [IW-1:0] mkInsn(logic [1:0] wc);
    return 32'h7C00_003C | (IW'(wc) << 21);
  endfunction

  // accept a wait with the given condition, then one idle cycle for completion
  task automatic issueWait(string tag, logic [1:0] wc);
    clr(); inValid = 1; isWaitOp = 1; insnIn = mkInsn(wc);
    step(tag);
    clr();
    chk(tag, "waitState after accept", waitState, 0);
    step(tag);
  endtask

  task automatic finishRun();
    if (!done) begin
      done = 1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog expired actual=running expected=finished");
    finishRun();
  end

  initial begin
    void'($urandom(32'd4242));
    clr();
    mWait = 0; mStValid = 0; mStEnter = 0; mInsn = '0; mDec = '0;
    repeat (3) @(negedge clk);
    // R7 reset state
    chk("R7", "waitState", waitState, 0);
    chk("R7", "busyOut", busyOut, 0);
    chk("R7", "heldInsn", heldInsn, 0);
    chk("R7", "decValue", decValue, 0);
    rstN = 1;
    // park decrementer at a positive value
    decLoad = 1; decLoadVal = 16'h4000; step("R9"); clr();
    chk("R9", "decValue loaded", decValue, 16'h4000);

    // R1 entry, R4 stall, R6 hold, R10 release, for every wake source (R3)
    for (int src = 0; src < 5; src++) begin
      issueWait("R1", 2'b00);
      chk("R1", "waitState set", waitState, 1);
      step("R4"); step("R4");
      chk("R4", "busyOut while waiting", busyOut, 1);
      inValid = 1; insnIn = 32'hDEAD_BEEF;
      step("R6"); step("R6");
      chk("R6", "heldInsn held", heldInsn, mkInsn(2'b00));
      chk("R5", "no accept while waiting", acceptOut, 0);
      clr();
      case (src)
        0: tracePending = 1;
        1: extIrq = 1;
        2: pmuIrq = 1;
        3: intrDeliver = 1;
        default: begin decLoad = 1; decLoadVal = 16'h8000; end
      endcase
      step("R3");
      clr();
      if (src == 4) begin
        decLoad = 1; decLoadVal = 16'h4000; step("R3"); clr();
      end
      chk("R3", "waitState woken", waitState, 0);
      chk("R10", "busyOut released", busyOut, 0);
      inValid = 1; insnIn = 32'h1234_5678;
      #1 chk("R10", "accept after wake", acceptOut, 1);
      step("R10"); clr(); step("R10");
    end

    // R2 nonzero condition field is a no-op
    for (int wc = 1; wc < 4; wc++) begin
      issueWait("R2", 2'(wc));
      step("R2");
      chk("R2", "waitState", waitState, 0);
      chk("R2", "busyOut", busyOut, 0);
    end

    // R11 non-wait instruction with zero field
    clr(); inValid = 1; isWaitOp = 0; insnIn = mkInsn(2'b00);
    step("R11"); clr(); step("R11"); step("R11");
    chk("R11", "waitState", waitState, 0);

    // R8 wake during completion cycle
    clr(); inValid = 1; isWaitOp = 1; insnIn = mkInsn(2'b00);
    step("R8"); clr(); pmuIrq = 1; step("R8"); clr();
    chk("R8", "waitState", waitState, 0);
    step("R8");
    chk("R8", "waitState later", waitState, 0);

    // R5 each blocker prevents acceptance
    for (int b = 0; b < 4; b++) begin
      clr(); inValid = 1; insnIn = 32'hA5A5_0000 | b;
      case (b)
        0: flushIn = 1;
        1: redirectIn = 1;
        2: intrActive = 1;
        default: unitBusy = 3'b100;
      endcase
      #1 chk("R5", "acceptOut blocked", acceptOut, 0);
      step("R5");
    end
    clr(); unitBusy = 3'b010;
    #1 chk("R4", "busyOut from unit", busyOut, 1);
    step("R4"); clr();

    // R9 count down through zero and wake
    decLoad = 1; decLoadVal = 16'd2; step("R9"); clr();
    decTick = 1; decLoad = 1; decLoadVal = 16'd2; step("R9");
    decLoad = 0;
    chk("R9", "load beats tick", decValue, 16'd2);
    step("R9"); step("R9");
    chk("R9", "reached zero", decValue, 16'd0);
    step("R9"); clr();
    chk("R9", "wrapped", decValue, 16'hFFFF);
    issueWait("R9", 2'b00);
    step("R9");
    chk("R9", "negative dec keeps awake", waitState, 0);
    decLoad = 1; decLoadVal = 16'h4000; step("R9"); clr();

    // random phase
    for (int i = 0; i < 600; i++) begin
      clr();
      inValid = 1'($urandom % 2);
      isWaitOp = ($urandom % 3) == 0;
      insnIn = $urandom;
      if ($urandom % 2 == 0) insnIn[22:21] = 2'b00;
      for (int k = 0; k < NB; k++) unitBusy[k] = ($urandom % 8) == 0;
      flushIn = ($urandom % 16) == 0;
      redirectIn = ($urandom % 16) == 0;
      intrActive = ($urandom % 16) == 0;
      tracePending = ($urandom % 32) == 0;
      extIrq = ($urandom % 32) == 0;
      pmuIrq = ($urandom % 32) == 0;
      intrDeliver = ($urandom % 32) == 0;
      decLoad = ($urandom % 20) == 0;
      decLoadVal = 16'($urandom % 64);
      if ($urandom % 4 == 0) decLoadVal[DW-1] = 1'b1;
      decTick = 1'($urandom % 2);
      step("R4");
    end
    clr();
    step("R4");
    finishRun();
  end
endmodule